// File: doc/BRIEF.md
# Base-and-Bounds Address Relocator

This block maps each virtual address produced by a processor onto a physical address by means of one base register and one bound register. On a request the virtual address is added to the base. In the same cycle, and in parallel with that sum, the address is compared against the bound. An address at or above the bound is refused with a protection fault. The outcome, either a translated address with a valid strobe or a fault flag, is registered and appears one clock after the request.

Supervisor software owns the relocation state. A single privileged write loads base and bound together, so a half-updated pair is never seen. A separate status-word enable bit switches translation on or off. While it is off, addresses pass through unchanged and no limit applies. A trap or interrupt entry clears that bit, so the supervisor can reach all of memory. A write from user mode, to either the relocation pair or the enable bit, has no effect and raises a privilege-violation pulse.

Top module: `bb_relocator`

## Requirements
- R1: After a synchronous reset, rsp_valid, rsp_fault, priv_fault and xlate_on are 0, rsp_paddr is 0, base is 0 and bound is 0.
- R2: With translation on and a virtual address below the bound, the cycle after req_valid shows rsp_valid=1, rsp_fault=0 and rsp_paddr = (base + vaddr) modulo 2^PA_W.
- R3: With translation on and a virtual address greater than or equal to the bound, including an address equal to it, the cycle after req_valid shows rsp_fault=1, rsp_valid=0 and rsp_paddr=0. A bound of 0 makes every access fault.
- R4: With translation off, the cycle after req_valid shows rsp_valid=1, rsp_fault=0 and rsp_paddr equal to vaddr zero-extended, whatever the base and bound are.
- R5: Each request produces exactly one of rsp_valid or rsp_fault in the next cycle. Neither is raised in a cycle that does not follow a request.
- R6: A cfg_wr with priv=1 loads cfg_base and cfg_bound together. They govern requests from the next cycle on. A request in the same cycle as the write still uses the previous pair.
- R7: A cfg_wr with priv=0 leaves base and bound unchanged and raises priv_fault for one cycle in the next cycle.
- R8: A stat_wr with priv=1 sets the enable bit to stat_din, and xlate_on shows it the next cycle. A stat_wr with priv=0 leaves the bit unchanged and raises priv_fault in the next cycle.
- R9: trap_enter clears the enable bit in the next cycle. It takes precedence over a stat_wr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_vaddr | input | VA_W | Virtual address of the access |
| priv | input | 1 | 1 when the requester runs in supervisor mode |
| cfg_wr | input | 1 | Write strobe for the base/bound pair |
| cfg_base | input | PA_W | New base value |
| cfg_bound | input | VA_W | New bound value (first illegal address) |
| stat_wr | input | 1 | Write strobe for the translation-enable bit |
| stat_din | input | 1 | New value of the translation-enable bit |
| trap_enter | input | 1 | Trap or interrupt entry, clears the enable bit |
| rsp_valid | output | 1 | Legal access, rsp_paddr is valid |
| rsp_fault | output | 1 | Bound violation for the previous request |
| rsp_paddr | output | PA_W | Physical address, 0 on a fault |
| priv_fault | output | 1 | A user-mode write to relocation state was refused |
| xlate_on | output | 1 | Current value of the translation-enable bit |

## Verification
The assertions assume that cfg_wr, stat_wr and trap_enter are ordinary strobes, free to coincide with requests. They also assume that req_vaddr is stable only while req_valid is high. The pass-through check compares against the address sampled with the request. The stimulus drives every input on the falling edge and lowers all strobes between operations, so each request's response can be matched to it alone. The one exception is the deliberate same-cycle overlap of a write and a request, or of a trap and a status write.

// File: rtl/bb_reloc_pkg.sv
package bb_reloc_pkg;

  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_GRANT = 2'd1,
    RSP_DENY  = 2'd2
  } rsp_kind_e;

endpackage

// File: rtl/bb_reloc_regs.sv
module bb_reloc_regs #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            priv,
  input  logic [PA_W-1:0] din_base,
  input  logic [VA_W-1:0] din_bound,
  output logic [PA_W-1:0] base_q,
  output logic [VA_W-1:0] bound_q,
  output logic            reject
);

  logic accept;

  assign accept = wr & priv;
  assign reject = wr & ~priv;

  // base and bound share one enable so they always move together
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      bound_q <= '0;
    end else if (accept) begin
      base_q  <= din_base;
      bound_q <= din_bound;
    end
  end

endmodule

// File: rtl/bb_reloc_status.sv
module bb_reloc_status (
  input  logic clk,
  input  logic rst,
  input  logic priv,
  input  logic stat_wr,
  input  logic stat_din,
  input  logic trap_enter,
  output logic en_q,
  output logic reject
);

  assign reject = stat_wr & ~priv;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (trap_enter) begin
      en_q <= 1'b0;
    end else if (stat_wr && priv) begin
      en_q <= stat_din;
    end
  end

endmodule

// File: rtl/bb_reloc_xlate.sv
module bb_reloc_xlate #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic            en,
  input  logic [PA_W-1:0] base,
  input  logic [VA_W-1:0] bound,
  input  logic [VA_W-1:0] vaddr,
  output logic [PA_W-1:0] paddr,
  output logic            legal
);

  localparam int EXT_W = PA_W - VA_W;

  logic [PA_W-1:0] va_ext;
  logic [PA_W-1:0] sum;
  logic            below;

  generate
    if (EXT_W == 0) begin : g_same_width
      assign va_ext = vaddr;
    end else begin : g_zero_extend
      assign va_ext = {{EXT_W{1'b0}}, vaddr};
    end
  endgenerate

  // adder and comparator are independent paths, both fed from vaddr
  assign sum   = base + va_ext;
  assign below = (vaddr < bound);

  assign legal = ~en | below;
  assign paddr = en ? sum : va_ext;

endmodule

// File: rtl/bb_relocator.sv
module bb_relocator
  import bb_reloc_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            priv,
  input  logic            cfg_wr,
  input  logic [PA_W-1:0] cfg_base,
  input  logic [VA_W-1:0] cfg_bound,
  input  logic            stat_wr,
  input  logic            stat_din,
  input  logic            trap_enter,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            priv_fault,
  output logic            xlate_on
);

  logic [PA_W-1:0] base_q;
  logic [VA_W-1:0] bound_q;
  logic            en_q;
  logic            cfg_reject;
  logic            stat_reject;
  logic [PA_W-1:0] xl_paddr;
  logic            xl_legal;
  rsp_kind_e       kind_d;
  rsp_kind_e       kind_q;
  logic [PA_W-1:0] paddr_q;
  logic            pfault_q;

  bb_reloc_regs #(.VA_W(VA_W), .PA_W(PA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (cfg_wr),
    .priv      (priv),
    .din_base  (cfg_base),
    .din_bound (cfg_bound),
    .base_q    (base_q),
    .bound_q   (bound_q),
    .reject    (cfg_reject)
  );

  bb_reloc_status u_status (
    .clk        (clk),
    .rst        (rst),
    .priv       (priv),
    .stat_wr    (stat_wr),
    .stat_din   (stat_din),
    .trap_enter (trap_enter),
    .en_q       (en_q),
    .reject     (stat_reject)
  );

  bb_reloc_xlate #(.VA_W(VA_W), .PA_W(PA_W)) u_xlate (
    .en    (en_q),
    .base  (base_q),
    .bound (bound_q),
    .vaddr (req_vaddr),
    .paddr (xl_paddr),
    .legal (xl_legal)
  );

  always_comb begin
    if (!req_valid)    kind_d = RSP_IDLE;
    else if (xl_legal) kind_d = RSP_GRANT;
    else               kind_d = RSP_DENY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= RSP_IDLE;
      paddr_q  <= '0;
      pfault_q <= 1'b0;
    end else begin
      kind_q   <= kind_d;
      paddr_q  <= (kind_d == RSP_GRANT) ? xl_paddr : '0;
      pfault_q <= cfg_reject | stat_reject;
    end
  end

  assign rsp_valid  = (kind_q == RSP_GRANT);
  assign rsp_fault  = (kind_q == RSP_DENY);
  assign rsp_paddr  = paddr_q;
  assign priv_fault = pfault_q;
  assign xlate_on   = en_q;

endmodule

// File: rtl/bb_relocator_checker.sv
module bb_relocator_checker #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            priv,
  input logic            cfg_wr,
  input logic            stat_wr,
  input logic            trap_enter,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            priv_fault,
  input logic            xlate_on
);

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_valid ^ rsp_fault));

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(rsp_valid || rsp_fault));

  assert_fault_zero_addr_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_paddr == '0));

  assert_bypass_identity_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !xlate_on && !trap_enter) |=>
      (rsp_valid && rsp_paddr == PA_W'($past(req_vaddr))));

  assert_user_cfg_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !priv) |=> priv_fault);

  assert_user_stat_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !priv && !trap_enter) |=> (priv_fault && $stable(xlate_on)));

  assert_flag_cause_R7: assert property (@(posedge clk) disable iff (rst)
    !((cfg_wr || stat_wr) && !priv) |=> !priv_fault);

  assert_trap_clears_R9: assert property (@(posedge clk) disable iff (rst)
    trap_enter |=> !xlate_on);

endmodule

bind bb_relocator bb_relocator_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_vaddr  (req_vaddr),
  .priv       (priv),
  .cfg_wr     (cfg_wr),
  .stat_wr    (stat_wr),
  .trap_enter (trap_enter),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_paddr  (rsp_paddr),
  .priv_fault (priv_fault),
  .xlate_on   (xlate_on)
);

// File: tb/bb_relocator_tb.sv
module bb_relocator_tb;

  localparam int VA_W = 6;
  localparam int PA_W = 8;
  localparam int NVA  = 1 << VA_W;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic            priv = 1'b0;
  logic            cfg_wr = 1'b0;
  logic [PA_W-1:0] cfg_base = '0;
  logic [VA_W-1:0] cfg_bound = '0;
  logic            stat_wr = 1'b0;
  logic            stat_din = 1'b0;
  logic            trap_enter = 1'b0;
  logic            rsp_valid;
  logic            rsp_fault;
  logic [PA_W-1:0] rsp_paddr;
  logic            priv_fault;
  logic            xlate_on;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  bb_relocator #(.VA_W(VA_W), .PA_W(PA_W)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .priv       (priv),
    .cfg_wr     (cfg_wr),
    .cfg_base   (cfg_base),
    .cfg_bound  (cfg_bound),
    .stat_wr    (stat_wr),
    .stat_din   (stat_din),
    .trap_enter (trap_enter),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_paddr  (rsp_paddr),
    .priv_fault (priv_fault),
    .xlate_on   (xlate_on)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one request; response sampled on the following falling edge
  task automatic access(input int va, input bit en, input int base, input int bound,
                        input string req);
    int exp_ok;
    int exp_pa;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = VA_W'(va);
    @(negedge clk);
    req_valid = 1'b0;
    if (!en) begin
      exp_ok = 1; exp_pa = va;
    end else if (va < bound) begin
      exp_ok = 1; exp_pa = (base + va) % (1 << PA_W);
    end else begin
      exp_ok = 0; exp_pa = 0;
    end
    check({req, " valid"}, int'(rsp_valid), exp_ok);
    check({req, " fault"}, int'(rsp_fault), 1 - exp_ok);
    check({req, " paddr"}, int'(rsp_paddr), exp_pa);
  endtask

  task automatic sweep(input bit en, input int base, input int bound, input string req);
    for (int v = 0; v < NVA; v++) access(v, en, base, bound, req);
  endtask

  task automatic write_cfg(input bit p, input int base, input int bound);
    @(negedge clk);
    priv = p; cfg_wr = 1'b1;
    cfg_base = PA_W'(base); cfg_bound = VA_W'(bound);
    @(negedge clk);
    cfg_wr = 1'b0; priv = 1'b0;
  endtask

  task automatic write_stat(input bit p, input bit val);
    @(negedge clk);
    priv = p; stat_wr = 1'b1; stat_din = val;
    @(negedge clk);
    stat_wr = 1'b0; priv = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 rsp_fault", int'(rsp_fault), 0);
    check("R1 rsp_paddr", int'(rsp_paddr), 0);
    check("R1 priv_fault", int'(priv_fault), 0);
    check("R1 xlate_on", int'(xlate_on), 0);
    // R1: base=0, bound=0 at reset -> enabling makes all accesses fault
    write_stat(1'b1, 1'b1);
    access(0, 1'b1, 0, 0, "R1 reset bound");
    write_stat(1'b1, 1'b0);

    // R4 translation off: identity over the whole space
    sweep(1'b0, 0, 0, "R4 bypass");

    // R6 privileged load, then R2/R3 full sweep
    write_cfg(1'b1, 200, 40);
    sweep(1'b0, 200, 40, "R4 bypass ignores base");
    write_stat(1'b1, 1'b1);
    check("R8 enable set", int'(xlate_on), 1);
    check("R8 priv write no flag", int'(priv_fault), 0);
    sweep(1'b1, 200, 40, "R2 R3 base200 bound40");
    access(39, 1'b1, 200, 40, "R2 last legal");
    access(40, 1'b1, 200, 40, "R3 equal bound");

    // R3 bound 0 and near-full bound
    write_cfg(1'b1, 17, 0);
    sweep(1'b1, 17, 0, "R3 bound zero");
    write_cfg(1'b1, 5, NVA - 1);
    sweep(1'b1, 5, NVA - 1, "R2 R3 bound max");

    // R7 user write refused
    @(negedge clk);
    priv = 1'b0; cfg_wr = 1'b1; cfg_base = 8'd99; cfg_bound = 6'd3;
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R7 priv_fault pulse", int'(priv_fault), 1);
    @(negedge clk);
    check("R7 priv_fault one cycle", int'(priv_fault), 0);
    sweep(1'b1, 5, NVA - 1, "R7 regs unchanged");

    // R6 same-cycle write and request: request sees old pair
    @(negedge clk);
    priv = 1'b1; cfg_wr = 1'b1; cfg_base = 8'd100; cfg_bound = 6'd10;
    req_valid = 1'b1; req_vaddr = 6'd20;
    @(negedge clk);
    cfg_wr = 1'b0; priv = 1'b0; req_valid = 1'b0;
    check("R6 old pair valid", int'(rsp_valid), 1);
    check("R6 old pair paddr", int'(rsp_paddr), 25);
    access(20, 1'b1, 100, 10, "R6 new pair");
    access(9, 1'b1, 100, 10, "R6 new pair");

    // R8 user status write refused
    write_stat(1'b0, 1'b0);
    check("R8 user stat flag", int'(priv_fault), 1);
    check("R8 user stat ignored", int'(xlate_on), 1);
    access(9, 1'b1, 100, 10, "R8 still translating");

    // R5 no response without a request
    @(negedge clk);
    check("R5 idle valid", int'(rsp_valid), 0);
    check("R5 idle fault", int'(rsp_fault), 0);

    // R9 trap overrides a same-cycle privileged enable write
    @(negedge clk);
    trap_enter = 1'b1; priv = 1'b1; stat_wr = 1'b1; stat_din = 1'b1;
    @(negedge clk);
    trap_enter = 1'b0; priv = 1'b0; stat_wr = 1'b0;
    check("R9 trap clears", int'(xlate_on), 0);
    sweep(1'b0, 100, 10, "R9 supervisor bypass");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule